// File: doc/BRIEF.md
# Threshold-Qualified Bidding Interrupt Arbiter

The block chooses which of several interrupt sources the host should serve next. Each source presents a composite bid. The bid is built from a programmable priority, an interrupt type, a FIFO fill level and the source's own channel number. A source bids only while it is requesting and enabled in the mask. A clocked, bit-serial scan on the system clock finds the largest bid. It works from the most significant bit down, one bit per cycle, so a full result is ready every `BID_W` cycles.

The active-low request `irq_n` is driven from the last completed scan. It is low only when that winning bid is strictly greater than a programmable threshold. The host captures the current winner into a current-interrupt register in one of two ways: by pulling the acknowledge low (the falling edge counts), or by pulsing an update command. The captured register is decoded into priority, type, fill level and channel number. For receive interrupts it also carries an error-data flag. Together these fields steer the selection of indirect global registers.

Top module: `bid_irq_arbiter`

## Requirements
- R1: After reset, `irq_n` is 1 and `cir_valid`, `cir_chan`, `cir_type`, `cir_fill`, `cir_prio` and `cir_err` are all 0.
- R2: The bid of source i is the 10-bit value {priority (3 bits), type (2 bits), fill (3 bits), i (2 bits)}, most significant field first. A captured bid comes back unchanged in `cir_prio`, `cir_type`, `cir_fill` and `cir_chan`.
- R3: A source takes part only when both its `src_req` bit and its `irq_mask` bit are 1. A source missing either bit never wins, even when its bid is the largest.
- R4: Once inputs have been stable for 2*BID_W cycles, `irq_n` is 0 exactly when the largest enabled bid is strictly greater than `threshold`. A bid equal to the threshold leaves `irq_n` at 1.
- R5: The winner is the enabled source with the largest bid. The priority field outranks the type field, the type field outranks the fill field, and the fill field outranks the channel field.
- R6: When priority, type and fill are equal, the source with the higher channel index wins.
- R7: A falling edge of `iack_n` captures the current scan result into the current-interrupt register. While `iack_n` stays low, no further capture happens.
- R8: A one-cycle pulse on `update_cmd` captures the current scan result in the same way as an acknowledge.
- R9: Type codes are 0 for change of state, 1 for transmit, 2 for receive and 3 for other.
- R10: `cir_err` is 1 only when the captured winner had its `src_err` bit set and its type is receive (2). An error bit on a winner of any other type reads 0.
- R11: With no enabled source, the scan result is empty. A capture then gives `cir_valid` = 0 and all fields 0, and `irq_n` stays 1 whatever the threshold.
- R12: Bids are sampled once per scan of BID_W cycles. A capture made within one cycle of an input change returns the previous scan's winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the scan advances one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Per-source interrupt request |
| irq_mask | input | NUM_SRC | Per-source bid enable |
| src_prio | input | NUM_SRC*PRIO_W | Programmable priority per source |
| src_type | input | NUM_SRC*2 | Interrupt type per source |
| src_fill | input | NUM_SRC*FILL_W | FIFO fill level per source |
| src_err | input | NUM_SRC | Error-data flag per source |
| threshold | input | BID_W | Bid that must be exceeded to raise the request |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| update_cmd | input | 1 | One-cycle command to capture the winner |
| irq_n | output | 1 | Active-low interrupt request |
| cir_valid | output | 1 | Captured result holds a real winner |
| cir_prio | output | PRIO_W | Captured priority field |
| cir_type | output | 2 | Captured interrupt type |
| cir_fill | output | FILL_W | Captured fill level |
| cir_chan | output | CH_W | Captured channel number |
| cir_err | output | 1 | Captured receive error-data flag |

## Verification
The scan is tried with bid sets that differ in only one field at a time. Priority-only differences show that the top field dominates. Sets where a low-priority source has the larger fill and type show that lower fields cannot outvote a higher one. Fully equal sets show that the channel index breaks the tie. Masking or dropping the request of the largest source checks that excluded bids cannot win. Setting the threshold equal to the winning bid, and then one below it, separates "strictly greater" from "greater or equal". A capture made right after a bid change tells a design that snapshots each scan apart from one that captures live inputs.

// File: rtl/bidarb_pkg.sv
package bidarb_pkg;
    localparam int TYPE_W = 2;

    typedef enum logic [TYPE_W-1:0] {
        SRC_COS  = 2'd0,
        SRC_TX   = 2'd1,
        SRC_RX   = 2'd2,
        SRC_MISC = 2'd3
    } src_type_e;
endpackage

// File: rtl/bidarb_pack.sv
module bidarb_pack #(
    parameter int NUM_SRC = 4,
    parameter int PRIO_W  = 3,
    parameter int FILL_W  = 3,
    parameter int CH_W    = 2,
    parameter int BID_W   = 10
) (
    input  logic [NUM_SRC*PRIO_W-1:0]             src_prio,
    input  logic [NUM_SRC*bidarb_pkg::TYPE_W-1:0] src_type,
    input  logic [NUM_SRC*FILL_W-1:0]             src_fill,
    output logic [NUM_SRC*BID_W-1:0]              bids
);
    localparam int TW = bidarb_pkg::TYPE_W;

    // Each bid is {priority, type, fill, own channel index}.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bid
        assign bids[g*BID_W +: BID_W] = {src_prio[g*PRIO_W +: PRIO_W],
                                         src_type[g*TW +: TW],
                                         src_fill[g*FILL_W +: FILL_W],
                                         CH_W'(g)};
    end
endmodule

// File: rtl/bidarb_scan.sv
module bidarb_scan #(
    parameter int NUM_SRC = 4,
    parameter int BID_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC*BID_W-1:0] bids,
    input  logic [NUM_SRC-1:0]       enable,
    input  logic [NUM_SRC-1:0]       err,
    output logic                     res_valid,
    output logic [BID_W-1:0]         res_bid,
    output logic                     res_err
);
    localparam int CNT_W = $clog2(BID_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BID_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]         cnt;
        logic [NUM_SRC-1:0]       alive;
        logic [NUM_SRC*BID_W-1:0] snap;
        logic [NUM_SRC-1:0]       snap_err;
        logic                     valid;
        logic [BID_W-1:0]         bid;
        logic                     err;
    } scan_st_t;

    scan_st_t s_d, s_q;

    logic [NUM_SRC-1:0]       cand;
    logic [NUM_SRC-1:0]       col;
    logic [NUM_SRC-1:0]       hit;
    logic [NUM_SRC-1:0]       nxt;
    logic [NUM_SRC*BID_W-1:0] bids_use;
    logic [NUM_SRC-1:0]       err_use;

    always_comb begin
        s_d      = s_q;
        cand     = (s_q.cnt == '0) ? enable : s_q.alive;
        bids_use = (s_q.cnt == '0) ? bids   : s_q.snap;
        err_use  = (s_q.cnt == '0) ? err    : s_q.snap_err;
        if (s_q.cnt == '0) begin
            s_d.snap     = bids;
            s_d.snap_err = err;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            col[i] = bids_use[i*BID_W + (BID_W - 1) - int'(s_q.cnt)];
        end
        hit       = cand & col;
        nxt       = (|hit) ? hit : cand;
        s_d.alive = nxt;
        if (s_q.cnt == LAST) begin
            s_d.cnt   = '0;
            s_d.valid = |nxt;
            s_d.bid   = '0;
            s_d.err   = 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (nxt[i]) begin
                    s_d.bid = s_d.bid | bids_use[i*BID_W +: BID_W];
                    s_d.err = s_d.err | err_use[i];
                end
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_valid = s_q.valid;
    assign res_bid   = s_q.bid;
    assign res_err   = s_q.err;

    // R6: the channel field makes every bid distinct, so one survivor at most
    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0) |-> $onehot0(s_q.alive));

    // R12: the bit counter stays inside one scan window
    p_cnt_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);
endmodule

// File: rtl/bidarb_cir.sv
module bidarb_cir #(
    parameter int BID_W  = 10,
    parameter int TYPE_L = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_n,
    input  logic             update_cmd,
    input  logic             res_valid,
    input  logic [BID_W-1:0] res_bid,
    input  logic             res_err,
    output logic             cir_valid,
    output logic [BID_W-1:0] cir_bid,
    output logic             cir_err
);
    import bidarb_pkg::*;

    typedef struct packed {
        logic             iack_prev;
        logic             valid;
        logic [BID_W-1:0] bid;
        logic             err;
    } cir_st_t;

    cir_st_t c_d, c_q;
    logic    cap;

    always_comb begin
        c_d           = c_q;
        c_d.iack_prev = iack_n;
        cap           = (!iack_n && c_q.iack_prev) || update_cmd;
        if (cap) begin
            c_d.valid = res_valid;
            c_d.bid   = res_bid;
            c_d.err   = res_err && (res_bid[TYPE_L +: TYPE_W] == SRC_RX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q           <= '0;
            c_q.iack_prev <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cir_valid = c_q.valid;
    assign cir_bid   = c_q.bid;
    assign cir_err   = c_q.err;

    // R7: a capture takes the result presented by the scanner
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (cir_bid == $past(res_bid)) && (cir_valid == $past(res_valid)));

    // R7: without a capture request the register holds its value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(cir_bid) && $stable(cir_valid) && $stable(cir_err));

    // R10: the error flag only accompanies a receive type
    p_err_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cir_err |-> (cir_bid[TYPE_L +: TYPE_W] == SRC_RX));
endmodule

// File: rtl/bid_irq_arbiter.sv
module bid_irq_arbiter #(
    parameter  int NUM_SRC = 4,
    parameter  int PRIO_W  = 3,
    parameter  int FILL_W  = 3,
    localparam int CH_W    = $clog2(NUM_SRC),
    localparam int TW      = bidarb_pkg::TYPE_W,
    localparam int BID_W   = PRIO_W + TW + FILL_W + CH_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_req,
    input  logic [NUM_SRC-1:0]        irq_mask,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC*TW-1:0]     src_type,
    input  logic [NUM_SRC*FILL_W-1:0] src_fill,
    input  logic [NUM_SRC-1:0]        src_err,
    input  logic [BID_W-1:0]          threshold,
    input  logic                      iack_n,
    input  logic                      update_cmd,
    output logic                      irq_n,
    output logic                      cir_valid,
    output logic [PRIO_W-1:0]         cir_prio,
    output logic [TW-1:0]             cir_type,
    output logic [FILL_W-1:0]         cir_fill,
    output logic [CH_W-1:0]           cir_chan,
    output logic                      cir_err
);
    localparam int FILL_L = CH_W;
    localparam int TYPE_L = CH_W + FILL_W;
    localparam int PRIO_L = CH_W + FILL_W + TW;

    logic [NUM_SRC*BID_W-1:0] bids;
    logic [NUM_SRC-1:0]       enable;
    logic                     res_valid;
    logic [BID_W-1:0]         res_bid;
    logic                     res_err;
    logic [BID_W-1:0]         cir_bid;

    assign enable = src_req & irq_mask;

    bidarb_pack #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .FILL_W(FILL_W),
        .CH_W(CH_W), .BID_W(BID_W)
    ) u_pack (
        .src_prio(src_prio), .src_type(src_type), .src_fill(src_fill),
        .bids(bids)
    );

    bidarb_scan #(.NUM_SRC(NUM_SRC), .BID_W(BID_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .bids(bids), .enable(enable), .err(src_err),
        .res_valid(res_valid), .res_bid(res_bid), .res_err(res_err)
    );

    bidarb_cir #(.BID_W(BID_W), .TYPE_L(TYPE_L)) u_cir (
        .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .update_cmd(update_cmd),
        .res_valid(res_valid), .res_bid(res_bid), .res_err(res_err),
        .cir_valid(cir_valid), .cir_bid(cir_bid), .cir_err(cir_err)
    );

    assign irq_n    = !(res_valid && (res_bid > threshold));
    assign cir_chan = cir_bid[0 +: CH_W];
    assign cir_fill = cir_bid[FILL_L +: FILL_W];
    assign cir_type = cir_bid[TYPE_L +: TW];
    assign cir_prio = cir_bid[PRIO_L +: PRIO_W];

    // R4: a raised request always leaves a real winner to capture
    p_irq_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && update_cmd) |=> cir_valid);

    // R11: an empty capture carries no fields
    p_empty_cir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cir_valid |-> (cir_bid == '0) && !cir_err);
endmodule

// File: tb/bid_irq_arbiter_bench.sv
`timescale 1ns/1ps
module bid_irq_arbiter_bench;
    localparam int N  = 4;
    localparam int PW = 3;
    localparam int FW = 3;
    localparam int BW = 10;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [N-1:0]  src_req = '0, irq_mask = '0, src_err = '0;
    logic [N*PW-1:0] src_prio = '0;
    logic [N*2-1:0]  src_type = '0;
    logic [N*FW-1:0] src_fill = '0;
    logic [BW-1:0] threshold = '0;
    logic          iack_n = 1, update_cmd = 0;
    logic          irq_n, cir_valid, cir_err;
    logic [PW-1:0] cir_prio;
    logic [1:0]    cir_type;
    logic [FW-1:0] cir_fill;
    logic [1:0]    cir_chan;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bid_irq_arbiter u_bid_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .irq_mask(irq_mask),
        .src_prio(src_prio), .src_type(src_type), .src_fill(src_fill),
        .src_err(src_err), .threshold(threshold), .iack_n(iack_n),
        .update_cmd(update_cmd), .irq_n(irq_n), .cir_valid(cir_valid),
        .cir_prio(cir_prio), .cir_type(cir_type), .cir_fill(cir_fill),
        .cir_chan(cir_chan), .cir_err(cir_err)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_src(int i, int p, int t, int f, bit e, bit rq, bit mk);
        src_prio[i*PW +: PW] = PW'(p);
        src_type[i*2 +: 2]   = 2'(t);
        src_fill[i*FW +: FW] = FW'(f);
        src_err[i]  = e;
        src_req[i]  = rq;
        irq_mask[i] = mk;
    endtask

    function automatic int bid_of(int i);
        return (int'(src_prio[i*PW +: PW]) << 7) | (int'(src_type[i*2 +: 2]) << 5)
             | (int'(src_fill[i*FW +: FW]) << 2) | i;
    endfunction

    // Largest enabled bid, -1 when none
    function automatic int exp_max();
        int m = -1;
        for (int i = 0; i < N; i++)
            if (src_req[i] && irq_mask[i] && bid_of(i) > m) m = bid_of(i);
        return m;
    endfunction

    function automatic int got_bid();
        return (int'(cir_prio) << 7) | (int'(cir_type) << 5) | (int'(cir_fill) << 2) | int'(cir_chan);
    endfunction

    task automatic settle();
        repeat (22) @(negedge clk);
    endtask

    task automatic ack_capture();
        @(negedge clk) iack_n = 0;
        @(negedge clk) iack_n = 1;
    endtask

    task automatic cmd_capture();
        @(negedge clk) update_cmd = 1;
        @(negedge clk) update_cmd = 0;
    endtask

    task automatic t_reset();
        check("R1 irq_n", irq_n, 1);
        check("R1 cir_valid", cir_valid, 0);
        check("R1 fields", got_bid(), 0);
        check("R1 cir_err", cir_err, 0);
    endtask

    task automatic t_priority();
        set_src(0, 2, 3, 7, 0, 1, 1);
        set_src(1, 5, 0, 0, 0, 1, 1);
        set_src(2, 4, 3, 7, 0, 1, 1);
        set_src(3, 1, 2, 2, 0, 1, 1);
        settle(); ack_capture();
        check("R5 priority wins", got_bid(), exp_max());
        check("R2 chan field", cir_chan, 1);
        check("R2 prio field", cir_prio, 5);
        check("R9 type COS", cir_type, 0);
        check("R5 valid", cir_valid, 1);
        // same priority, type decides over fill
        set_src(1, 4, 1, 7, 0, 1, 1);
        set_src(2, 4, 2, 0, 0, 1, 1);
        settle(); ack_capture();
        check("R5 type over fill", cir_chan, 2);
        check("R2 fill field", cir_fill, 0);
    endtask

    task automatic t_tie();
        for (int i = 0; i < N; i++) set_src(i, 3, 1, 4, 0, 1, 1);
        settle(); cmd_capture();
        check("R6 higher channel wins", cir_chan, 3);
        irq_mask[3] = 0;
        settle(); cmd_capture();
        check("R6 next channel wins", cir_chan, 2);
    endtask

    task automatic t_mask();
        for (int i = 0; i < N; i++) set_src(i, 1, 0, i, 0, 1, 1);
        set_src(2, 7, 3, 7, 0, 1, 0);
        settle(); ack_capture();
        check("R3 masked source loses", cir_chan, 3);
        set_src(2, 7, 3, 7, 0, 0, 1);
        settle(); ack_capture();
        check("R3 idle source loses", cir_chan, 3);
        check("R3 bid", got_bid(), exp_max());
    endtask

    task automatic t_threshold();
        for (int i = 0; i < N; i++) set_src(i, 0, 0, 0, 0, 0, 1);
        set_src(1, 3, 2, 5, 0, 1, 1);
        threshold = BW'(exp_max());
        settle();
        check("R4 equal bid no irq", irq_n, 1);
        threshold = BW'(exp_max() - 1);
        @(negedge clk);
        check("R4 bid above threshold", irq_n, 0);
        threshold = '1;
        @(negedge clk);
        check("R4 max threshold", irq_n, 1);
        threshold = '0;
    endtask

    task automatic t_hold();
        int first;
        for (int i = 0; i < N; i++) set_src(i, 0, 0, 0, 0, 0, 1);
        set_src(0, 6, 1, 1, 0, 1, 1);
        settle();
        @(negedge clk) iack_n = 0;
        @(negedge clk);
        first = got_bid();
        check("R7 captured", first, exp_max());
        set_src(3, 7, 1, 1, 0, 1, 1);
        settle();
        check("R7 no recapture while low", got_bid(), first);
        @(negedge clk) iack_n = 1;
        ack_capture();
        check("R7 new edge captures", cir_chan, 3);
    endtask

    task automatic t_update();
        for (int i = 0; i < N; i++) set_src(i, 0, 0, 0, 0, 0, 1);
        set_src(2, 2, 1, 6, 0, 1, 1);
        settle(); cmd_capture();
        check("R8 update captures", got_bid(), exp_max());
        check("R9 type TX", cir_type, 1);
    endtask

    task automatic t_err();
        for (int i = 0; i < N; i++) set_src(i, 0, 0, 0, 0, 0, 1);
        set_src(1, 4, 2, 3, 1, 1, 1);
        set_src(0, 1, 2, 3, 0, 1, 1);
        settle(); ack_capture();
        check("R10 rx error flagged", cir_err, 1);
        check("R9 type RX", cir_type, 2);
        set_src(1, 4, 1, 3, 1, 1, 1);
        settle(); ack_capture();
        check("R10 tx error hidden", cir_err, 0);
        set_src(1, 4, 2, 3, 0, 1, 1);
        set_src(0, 1, 2, 3, 1, 1, 1);
        settle(); ack_capture();
        check("R10 loser error ignored", cir_err, 0);
    endtask

    task automatic t_none();
        for (int i = 0; i < N; i++) set_src(i, 7, 3, 7, 1, 1, 0);
        threshold = '0;
        settle(); cmd_capture();
        check("R11 no valid", cir_valid, 0);
        check("R11 zero fields", got_bid(), 0);
        check("R11 irq idle", irq_n, 1);
    endtask

    task automatic t_midscan();
        int old_bid;
        for (int i = 0; i < N; i++) set_src(i, 0, 0, 0, 0, 0, 1);
        set_src(0, 5, 0, 0, 0, 1, 1);
        settle();
        old_bid = exp_max();
        @(negedge clk);
        set_src(3, 7, 3, 7, 0, 1, 1);
        iack_n = 0;
        @(negedge clk) iack_n = 1;
        check("R12 previous scan used", got_bid(), old_bid);
        settle(); ack_capture();
        check("R12 next scan used", got_bid(), exp_max());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_tie();
        t_mask();
        t_threshold();
        t_hold();
        t_update();
        t_err();
        t_none();
        t_midscan();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule